// File: doc/BRIEF.md
# RC4 Two-Round Key Scheduler

This block turns a secret key of 1 to 16 bytes into the 256-entry RC4 state permutation. The state lives in flip-flops, so a keystream generator can read the finished permutation directly. Software or a controller first writes the key bytes into a small key bank and sets the key length. It then pulses `start`. The block spends one cycle filling the state with the identity and clearing `j`. It then retires two key-scheduling rounds per clock, which takes 128 cycles in all.

Each pair of rounds uses indices `2p` and `2p+1`. The two key bytes come from two 16-way selectors. Each selector is steered by its own wrapping counter that tracks `i mod len`, so no divider is needed. The second round of a pair must see the state left by the first round's swap, so its reads are forwarded from the first swap whenever the indices coincide. While the schedule runs, no keystream byte is produced. When it ends, `done` rises and stays high until the next start.

Top module: `ksa2_core`

## Requirements
- R1: After reset, `done` is 0 and every state entry S[x] reads back as x.
- R2: While the block is not scheduling, a high `key_we` writes `key_wdata` into key byte position `key_waddr`, where position p is the p-th key byte (position 0 is used by round 0).
- R3: Key writes presented while scheduling is in progress (fill cycle or round cycles) are dropped, and the key bank keeps its contents.
- R4: `key_len` is captured on the start cycle and used for the whole run. The value 0 and values above 16 act as 16. Round i uses key byte position (i mod length).
- R5: The first clock edge after the start edge sets S[x] = x for every x and sets j = 0, before any round is applied.
- R6: When `done` rises, the state equals the permutation that the standard one-round-at-a-time RC4 key schedule produces for the same key and length.
- R7: `done` is 0 while scheduling runs. It rises exactly 129 clock edges after the edge that samples `start` (1 fill cycle plus 128 round pairs), and it stays 1 until the next accepted start.
- R8: A `start` pulse during the fill cycle or the round cycles is ignored. It neither restarts nor lengthens the run.
- R9: `rd_data` shows S[`rd_addr`] combinationally from the current state.
- R10: The second round of each pair reads the state as left by the first round's swap, including the cases i2 = j1, j2 = j1 and j2 = i1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Key byte write enable |
| key_waddr | input | 4 | Key byte position to write |
| key_wdata | input | 8 | Key byte value |
| key_len | input | 5 | Key length in bytes, captured at start |
| start | input | 1 | Begin scheduling (accepted when idle or done) |
| done | output | 1 | Permutation complete |
| rd_addr | input | 8 | State read index |
| rd_data | output | 8 | State byte at `rd_addr` |

## Verification
Two short keys target the forwarding hazards. Key {1,255} forces i2 = j1 and then j2 = i1 in the first pair, and key {1,0} forces j2 = j1. A scheduler without forwarding reads stale bytes there and ends with a wrong permutation. Odd lengths (1, 5, 7, 13) make the two index counters wrap in different cycles, so a counter stepped or wrapped wrongly picks the wrong key byte. Directed runs cover the other cases, each of which would show up in the final state or in the cycle count:
- a length of 0 or 20 that must act as 16;
- a length changed in the middle of a run;
- a key write or a second start in the middle of a run;
- a restart from the done state, where a missing identity fill would leave the old permutation.

// File: rtl/ksa2_pkg.sv
package ksa2_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_RUN  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/ksa2_keybank.sv
module ksa2_keybank #(
    parameter int KEY_DEPTH = 16,
    parameter int W         = 8,
    localparam int KAW      = $clog2(KEY_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lock,
    input  logic                          we,
    input  logic [KAW-1:0]                waddr,
    input  logic [W-1:0]                  wdata,
    input  logic [1:0][KAW-1:0]           sel,
    output logic [1:0][W-1:0]             kbyte
);
    logic [KEY_DEPTH-1:0][W-1:0] key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (we && !lock) key_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    // one selector per unrolled round
    for (genvar g = 0; g < 2; g++) begin : g_sel
        assign kbyte[g] = key_q[sel[g]];
    end

    // R3: bank is frozen while scheduling
    a_r3_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(key_q));
endmodule

// File: rtl/ksa2_modctr.sv
module ksa2_modctr #(
    parameter int KEY_DEPTH = 16,
    parameter int LANE      = 0,
    localparam int KAW      = $clog2(KEY_DEPTH),
    localparam int LW       = KAW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [LW-1:0]  len,
    output logic [KAW-1:0] idx
);
    logic [LW-1:0] c_d, c_q, t;

    always_comb begin
        c_d = c_q;
        t   = c_q + LW'(2);
        if (load) begin
            c_d = (LW'(LANE) < len) ? LW'(LANE) : '0;
        end else if (step) begin
            // advance by two rounds; a length of 1 needs a second wrap
            if (t >= len) t = t - len;
            if (t >= len) t = t - len;
            c_d = t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign idx = c_q[KAW-1:0];

    // R4: the selector never reaches a key position at or above the length
    a_r4_sel_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (c_q < len));
endmodule

// File: rtl/ksa2_dual_round.sv
module ksa2_dual_round #(
    parameter int N  = 256,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] sbox,
    input  logic [W-1:0]        i1,
    input  logic [W-1:0]        j_in,
    input  logic [W-1:0]        k1,
    input  logic [W-1:0]        k2,
    output logic [W-1:0]        i2,
    output logic [W-1:0]        j1,
    output logic [W-1:0]        j2,
    output logic [W-1:0]        va,
    output logic [W-1:0]        vb,
    output logic [W-1:0]        vc,
    output logic [W-1:0]        vd
);
    always_comb begin
        i2 = i1 + W'(1);
        va = sbox[i1];
        j1 = j_in + va + k1;
        vb = sbox[j1];
        // first swap put va at j1 (and vb at i1)
        vc = (i2 == j1) ? va : sbox[i2];
        j2 = j1 + vc + k2;
        if (j2 == j1)      vd = va;
        else if (j2 == i1) vd = vb;
        else               vd = sbox[j2];
    end
endmodule

// File: rtl/ksa2_core.sv
module ksa2_core #(
    parameter int N         = 256,
    parameter int KEY_DEPTH = 16,
    localparam int W        = $clog2(N),
    localparam int KAW      = $clog2(KEY_DEPTH),
    localparam int LW       = KAW + 1,
    localparam int PAIRS    = N / 2,
    localparam int PW       = $clog2(PAIRS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           key_we,
    input  logic [KAW-1:0] key_waddr,
    input  logic [W-1:0]   key_wdata,
    input  logic [LW-1:0]  key_len,
    input  logic           start,
    output logic           done,
    input  logic [W-1:0]   rd_addr,
    output logic [W-1:0]   rd_data
);
    import ksa2_pkg::*;

    typedef struct packed {
        phase_e              ph;
        logic [PW-1:0]       pair;
        logic [W-1:0]        j;
        logic [LW-1:0]       len;
        logic [N-1:0][W-1:0] sbox;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [N-1:0][W-1:0] ident();
        logic [N-1:0][W-1:0] r;
        for (int x = 0; x < N; x++) r[x] = W'(x);
        return r;
    endfunction

    logic                 busy;
    logic [1:0][KAW-1:0]  sel;
    logic [1:0][W-1:0]    kbyte;
    logic [W-1:0]         i1, i2, j1, j2, va, vb, vc, vd;
    logic [LW-1:0]        len_eff;

    assign busy = (st_q.ph == PH_FILL) || (st_q.ph == PH_RUN);
    assign i1   = {st_q.pair, 1'b0};

    ksa2_keybank #(.KEY_DEPTH(KEY_DEPTH), .W(W)) u_keys (
        .clk(clk), .rst_n(rst_n), .lock(busy), .we(key_we),
        .waddr(key_waddr), .wdata(key_wdata), .sel(sel), .kbyte(kbyte)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        ksa2_modctr #(.KEY_DEPTH(KEY_DEPTH), .LANE(g)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .load(st_q.ph == PH_FILL), .step(st_q.ph == PH_RUN),
            .len(st_q.len), .idx(sel[g])
        );
    end

    ksa2_dual_round #(.N(N)) u_rounds (
        .sbox(st_q.sbox), .i1(i1), .j_in(st_q.j), .k1(kbyte[0]), .k2(kbyte[1]),
        .i2(i2), .j1(j1), .j2(j2), .va(va), .vb(vb), .vc(vc), .vd(vd)
    );

    always_comb begin
        if (key_len == '0 || key_len > LW'(KEY_DEPTH)) len_eff = LW'(KEY_DEPTH);
        else                                           len_eff = key_len;
    end

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    st_d.ph  = PH_FILL;
                    st_d.len = len_eff;
                end
            end
            PH_FILL: begin
                st_d.sbox = ident();
                st_d.j    = '0;
                st_d.pair = '0;
                st_d.ph   = PH_RUN;
            end
            default: begin
                // later writes win: second swap overrides the first
                st_d.sbox[i1] = vb;
                st_d.sbox[j1] = va;
                st_d.sbox[i2] = vd;
                st_d.sbox[j2] = vc;
                st_d.j        = j2;
                st_d.pair     = st_q.pair + PW'(1);
                if (st_q.pair == PW'(PAIRS - 1)) st_d.ph = PH_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.pair <= '0;
            st_q.j    <= '0;
            st_q.len  <= LW'(KEY_DEPTH);
            st_q.sbox <= ident();
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = (st_q.ph == PH_DONE);
    assign rd_data = st_q.sbox[rd_addr];

    // R4: second lane selector stays one position ahead of the first, modulo the length
    a_r4_lane_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN) |->
        ((LW'(sel[0]) + LW'(1) == st_q.len) ? (sel[1] == '0)
                                            : (LW'(sel[1]) == LW'(sel[0]) + LW'(1))));
    // R5: fill cycle leaves identity and cleared j
    a_r5_fill_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_FILL) |=> (st_q.ph == PH_RUN && st_q.j == '0 &&
                                  st_q.sbox[1] == W'(1) && st_q.sbox[N-1] == W'(N-1)));
    // R7: round pairs advance one per cycle
    a_r7_pair_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && st_q.pair != PW'(PAIRS - 1)) |=>
        (st_q.ph == PH_RUN && st_q.pair == $past(st_q.pair) + PW'(1)));
    // R7: done holds until a new start
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R8: start while running does not restart
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && start) |=> (st_q.ph != PH_FILL));
endmodule

// File: tb/ksa2_core_test.sv
module ksa2_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_we = 1'b0;
    logic [3:0] key_waddr = '0;
    logic [7:0] key_wdata = '0;
    logic [4:0] key_len = 5'd16;
    logic       start = 1'b0;
    logic       done;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    int exp_s [256];
    int cyc = 0;

    ksa2_core uut (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_waddr(key_waddr),
        .key_wdata(key_wdata), .key_len(key_len), .start(start), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam int NV = 7;
    localparam logic [NV-1:0][4:0] V_LEN = {5'd16, 5'd13, 5'd7, 5'd5, 5'd1, 5'd2, 5'd2};
    localparam logic [NV-1:0][127:0] V_KEY = {
        128'hf0e1d2c3b4a5968778695a4b3c2d1e0f,
        128'h0d0c0b0a09080706050403020f,
        128'h11223344556677,
        128'h3ca710e29b,
        128'h5a,
        128'h0001,
        128'hff01
    };

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic ref_ksa(input logic [127:0] key, input int len);
        int j = 0;
        int t;
        for (int i = 0; i < 256; i++) exp_s[i] = i;
        for (int i = 0; i < 256; i++) begin
            j = (j + exp_s[i] + int'(key[8*(i % len) +: 8])) % 256;
            t = exp_s[i]; exp_s[i] = exp_s[j]; exp_s[j] = t;
        end
    endtask

    task automatic load_key(input logic [127:0] key, input logic [4:0] len);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            key_we = 1'b1; key_waddr = 4'(p); key_wdata = key[8*p +: 8];
        end
        @(negedge clk);
        key_we = 1'b0;
        key_len = len;
    endtask

    // kind: 0 none, 1 start pulse, 2 key write, 3 key_len change
    task automatic run_ksa(input int inj_at, input int kind, output int edges);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        chk(done == 1'b0, "R7 done low after start", int'(done), 0);
        while (!done && edges < 400) begin
            if (edges == inj_at) begin
                if (kind == 1) start = 1'b1;
                if (kind == 2) begin key_we = 1'b1; key_waddr = 4'd0; key_wdata = 8'hc3; end
                if (kind == 3) key_len = 5'd3;
            end
            @(negedge clk);
            edges = edges + 1;
            start = 1'b0;
            key_we = 1'b0;
        end
    endtask

    task automatic perm_check(input string req);
        int bad = 0;
        int fa = 0, fv = 0, fe = 0;
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #1;
            if (int'(rd_data) != exp_s[a]) begin
                if (bad == 0) begin fa = a; fv = int'(rd_data); fe = exp_s[a]; end
                bad = bad + 1;
            end
        end
        if (bad != 0) $display("  first mismatch at S[%0d]", fa);
        chk(bad == 0, req, fv, fe);
    endtask

    initial begin
        int edges;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        for (int x = 0; x < 256; x++) exp_s[x] = x;
        perm_check("R1 R9 identity after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // table of keys and lengths; entries 0 and 1 force the forwarding hazards (R10)
        for (int v = 0; v < NV; v++) begin
            load_key(V_KEY[v], V_LEN[v]);
            ref_ksa(V_KEY[v], int'(V_LEN[v]));
            run_ksa(-1, 0, edges);
            chk(edges == 130, "R7 done timing", edges, 130);
            if (v < 2) perm_check("R10 R6 R2 hazard key permutation");
            else       perm_check("R6 R2 R4 R9 permutation");
        end

        // R7: done holds
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", int'(done), 1);

        // R4: length 0 and 20 act as 16
        load_key(V_KEY[6], 5'd0);
        ref_ksa(V_KEY[6], 16);
        run_ksa(-1, 0, edges);
        perm_check("R4 length 0 acts as 16");
        key_len = 5'd20;
        run_ksa(-1, 0, edges);
        perm_check("R4 length 20 acts as 16");

        // R4: length captured at start
        load_key(V_KEY[3], 5'd5);
        ref_ksa(V_KEY[3], 5);
        run_ksa(40, 3, edges);
        perm_check("R4 length change mid-run ignored");
        key_len = 5'd5;

        // R3: key write mid-run is dropped, and the bank keeps the key
        load_key(V_KEY[4], 5'd7);
        ref_ksa(V_KEY[4], 7);
        run_ksa(60, 2, edges);
        perm_check("R3 key write mid-run ignored");
        run_ksa(1, 2, edges);
        perm_check("R3 key bank intact after dropped writes");

        // R8: start mid-run ignored
        run_ksa(70, 1, edges);
        chk(edges == 130, "R8 start mid-run timing", edges, 130);
        perm_check("R8 start mid-run result");

        // R5: restart from done fills identity on the first edge
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 done drops on restart", int'(done), 1'b0);
        @(negedge clk);
        rd_addr = 8'd3;
        #1;
        chk(rd_data == 8'd3, "R5 identity after fill S[3]", int'(rd_data), 3);
        rd_addr = 8'd200;
        #1;
        chk(rd_data == 8'd200, "R5 identity after fill S[200]", int'(rd_data), 200);
        while (!done) @(negedge clk);
        perm_check("R6 restart result");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule